// File: doc/BRIEF.md
# Serial Port Register and Command Front End

This block sits between a byte-wide register bus and the data path of a serial port. It holds the mode and configuration state and turns single-byte command writes into enable, disable and reset actions for the two directions. It also passes transmit bytes to a serializer through a valid/ready handshake and forwards reads of the receive data offset to an external receive FIFO. One level-sensitive interrupt line combines masked transmit, receive and break-change conditions.

Software reaches two mode registers at one offset through a pointer. Every mode write moves the pointer to the second register, and a command resets it. One command byte carries three fields: a miscellaneous action, a transmitter action and a receiver action. The receive interrupt can be set to follow either "FIFO full" or "data available", depending on a bit in the first mode register. Bit shifting, baud timing and the receive FIFO storage are outside this block. The FIFO is driven through pop, flush and enable lines, and it reports empty, full and its head byte.

Register accesses use `sel_i` with `wr_i` and an exact 6-bit offset. A write takes effect at the clock edge where it is presented. Read data is combinational from the offset.

Top module: `uart_regif`

## Requirements
- R1: After reset both mode registers, the mode pointer, the interrupt flags and the interrupt mask are zero. Both directions are disabled, the status byte reads 0x08 and `irq_o` is low.
- R2: A write to offset 0x00 stores into the mode register the pointer selects and then sets the pointer to the second register. A read of 0x00 returns the selected register and leaves the pointer unchanged. Miscellaneous command 1 returns the pointer to the first register.
- R3: The status byte at offset 0x04 has bit0 set when the FIFO is not empty, bit1 equal to FIFO full, bit2 equal to the transmitter enable and bit3 set when the transmit buffer is empty. Bits 7:4 read zero. Writes to 0x04 change nothing.
- R4: A write to offset 0x08 is a command. Bits 6:4 are the miscellaneous action, bits 3:2 the transmitter action and bits 1:0 the receiver action. In a direction field, 1 enables, 2 disables, and 0 or 3 keep the state. The miscellaneous action takes effect before the direction fields, so a direction field can override a reset in the same byte. Miscellaneous values 0, 4, 6 and 7 do nothing. `rx_en_o` is the receiver enable.
- R5: Miscellaneous value 3 disables the transmitter and marks the buffer empty, which drops a pending byte. Value 2 disables the receiver and pulses `rx_flush_o` in the cycle of the write.
- R6: A write to 0x0C loads the transmit buffer and marks it not empty. `tx_valid_o` is high exactly when the transmitter is enabled and the buffer is not empty. `tx_data_o` holds the loaded byte. The buffer becomes empty at the edge where `tx_valid_o` and `tx_ready_i` are both high, unless a new byte is loaded in that same cycle.
- R7: A read of 0x0C returns `rx_data_i` and pulses `rx_pop_o` when the FIFO is not empty. It returns 0 and does not pop when the FIFO is empty.
- R8: The interrupt flags at offset 0x14 hold three bits. Bit0 equals the transmitter enable and changes at the same edge. Bit1 is registered from FIFO full when mode register A bit6 is set, and from FIFO not empty otherwise. Bit2 is set by `brk_i` and cleared by miscellaneous value 5; the set wins if both occur together.
- R9: A write to 0x14 loads the interrupt mask. `irq_o` is high whenever any flag bit and the same mask bit are both set.
- R10: Offsets 0x18 and 0x1C store the low and high divisor bytes. They read back and drive `div_lo_o` and `div_hi_o`.
- R11: Reads of 0x10 and of every unmapped offset return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request, level |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Serializer accepts byte |
| brk_i | input | 1 | Break-change event pulse |
| rx_en_o | output | 1 | Receiver enable for the FIFO writer |
| rx_pop_o | output | 1 | Pop the FIFO head |
| rx_flush_o | output | 1 | Empty the FIFO |
| rx_empty_i | input | 1 | FIFO empty |
| rx_full_i | input | 1 | FIFO full |
| rx_data_i | input | 8 | FIFO head byte |
| div_lo_o | output | 8 | Divisor low byte |
| div_hi_o | output | 8 | Divisor high byte |

## Verification
A wrong enable or buffer-empty state appears on the edge right after the access that causes it. The status byte shows it, `tx_valid_o` is offered or withheld wrongly, or the transmit interrupt flag moves `irq_o` in that same cycle. A receive interrupt flag with the wrong source shows one cycle after the FIFO changes. A mode pointer that goes to the wrong place stays hidden until the next read of offset 0x00, so the bench reads that offset often, including right after writes and pointer resets.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CMD  = 8'h08;
  localparam logic [7:0] OFS_DATA = 8'h0C;
  localparam logic [7:0] OFS_AUX  = 8'h10;
  localparam logic [7:0] OFS_INT  = 8'h14;
  localparam logic [7:0] OFS_DIVL = 8'h18;
  localparam logic [7:0] OFS_DIVH = 8'h1C;

  localparam int unsigned ST_RXRDY = 0;
  localparam int unsigned ST_FULL  = 1;
  localparam int unsigned ST_TXRDY = 2;
  localparam int unsigned ST_TXEMP = 3;

  localparam int unsigned IS_TX  = 0;
  localparam int unsigned IS_RX  = 1;
  localparam int unsigned IS_BRK = 2;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_RST = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_RST = 3'd4,
    MISC_BRK_CLR = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_cmd_e;

  typedef enum logic [1:0] {
    DIR_KEEP = 2'd0,
    DIR_ON   = 2'd1,
    DIR_OFF  = 2'd2,
    DIR_RSVD = 2'd3
  } dir_cmd_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
  } misc_act_t;

endpackage

// File: rtl/uart_regif_cmd.sv
module uart_regif_cmd
  import uart_regif_pkg::*;
(
  input  logic       apply_i,
  input  logic [6:0] cmd_i,
  input  logic       tx_en_i,
  input  logic       rx_en_i,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output misc_act_t  act_o
);

  misc_cmd_e misc;
  dir_cmd_e  tx_f;
  dir_cmd_e  rx_f;

  assign misc = misc_cmd_e'(cmd_i[6:4]);
  assign tx_f = dir_cmd_e'(cmd_i[3:2]);
  assign rx_f = dir_cmd_e'(cmd_i[1:0]);

  // misc stage first, direction fields may override it
  always_comb begin
    act_o   = '0;
    tx_en_o = tx_en_i;
    rx_en_o = rx_en_i;
    if (apply_i) begin
      unique case (misc)
        MISC_PTR_RST: act_o.ptr_rst = 1'b1;
        MISC_RX_RST: begin
          act_o.rx_rst = 1'b1;
          rx_en_o      = 1'b0;
        end
        MISC_TX_RST: begin
          act_o.tx_rst = 1'b1;
          tx_en_o      = 1'b0;
        end
        MISC_BRK_CLR: act_o.brk_clr = 1'b1;
        MISC_NOP, MISC_ERR_RST, MISC_BRK_ON, MISC_BRK_OFF: ;
      endcase
      unique case (tx_f)
        DIR_ON:  tx_en_o = 1'b1;
        DIR_OFF: tx_en_o = 1'b0;
        DIR_KEEP, DIR_RSVD: ;
      endcase
      unique case (rx_f)
        DIR_ON:  rx_en_o = 1'b1;
        DIR_OFF: rx_en_o = 1'b0;
        DIR_KEEP, DIR_RSVD: ;
      endcase
    end
  end

endmodule

// File: rtl/uart_regif_txbuf.sv
module uart_regif_txbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              drop_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);

  logic              empty_q;
  logic [DATA_W-1:0] data_q;
  logic              hs;

  assign valid_o = en_i & ~empty_q;
  assign hs      = valid_o & ready_i;
  assign data_o  = data_q;
  assign empty_o = empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      data_q  <= '0;
    end else begin
      if (drop_i)      empty_q <= 1'b1;
      else if (load_i) empty_q <= 1'b0;
      else if (hs)     empty_q <= 1'b1;
      if (load_i) data_q <= load_data_i;
    end
  end

endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq
  import uart_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_int_d_i,
  input  logic              rx_int_d_i,
  input  logic              brk_set_i,
  input  logic              brk_clr_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] isr_o,
  output logic              irq_o
);

  logic tx_q, rx_q, brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      tx_q <= tx_int_d_i;
      rx_q <= rx_int_d_i;
      if (brk_set_i)      brk_q <= 1'b1;
      else if (brk_clr_i) brk_q <= 1'b0;
    end
  end

  always_comb begin
    isr_o         = '0;
    isr_o[IS_TX]  = tx_q;
    isr_o[IS_RX]  = rx_q;
    isr_o[IS_BRK] = brk_q;
  end

  assign irq_o = |(isr_o & mask_i);

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NUM_MODE  = 2,
  parameter int unsigned RXSEL_BIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  input  logic              brk_i,
  output logic              rx_en_o,
  output logic              rx_pop_o,
  output logic              rx_flush_o,
  input  logic              rx_empty_i,
  input  logic              rx_full_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic [DATA_W-1:0] div_lo_o,
  output logic [DATA_W-1:0] div_hi_o
);

  localparam int unsigned PTR_W = (NUM_MODE > 1) ? $clog2(NUM_MODE) : 1;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wr_acc, rd_acc;
  logic we_mode, we_cmd, we_data, we_mask, we_divl, we_divh;

  assign wr_acc  = sel_i & wr_i;
  assign rd_acc  = sel_i & ~wr_i;
  assign we_mode = wr_acc & hit(addr_i, OFS_MODE);
  assign we_cmd  = wr_acc & hit(addr_i, OFS_CMD);
  assign we_data = wr_acc & hit(addr_i, OFS_DATA);
  assign we_mask = wr_acc & hit(addr_i, OFS_INT);
  assign we_divl = wr_acc & hit(addr_i, OFS_DIVL);
  assign we_divh = wr_acc & hit(addr_i, OFS_DIVH);

  // command decode
  logic      tx_en_q, rx_en_q, tx_en_d, rx_en_d;
  misc_act_t act;

  uart_regif_cmd u_cmd (
    .apply_i (we_cmd),
    .cmd_i   (wdata_i[6:0]),
    .tx_en_i (tx_en_q),
    .rx_en_i (rx_en_q),
    .tx_en_o (tx_en_d),
    .rx_en_o (rx_en_d),
    .act_o   (act)
  );

  // mode registers behind an advancing pointer
  logic [PTR_W-1:0]              ptr_q;
  logic [NUM_MODE-1:0][DATA_W-1:0] mode_q;
  logic [DATA_W-1:0]             mask_q, divl_q, divh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      ptr_q   <= '0;
      mode_q  <= '0;
      mask_q  <= '0;
      divl_q  <= '0;
      divh_q  <= '0;
    end else begin
      tx_en_q <= tx_en_d;
      rx_en_q <= rx_en_d;
      if (act.ptr_rst)  ptr_q <= '0;
      else if (we_mode) ptr_q <= PTR_W'(1);
      for (int i = 0; i < int'(NUM_MODE); i++) begin
        if (we_mode && ptr_q == PTR_W'(i)) mode_q[i] <= wdata_i;
      end
      if (we_mask) mask_q <= wdata_i;
      if (we_divl) divl_q <= wdata_i;
      if (we_divh) divh_q <= wdata_i;
    end
  end

  // transmit handoff
  logic txemp;

  uart_regif_txbuf #(.DATA_W(DATA_W)) u_txbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (tx_en_q),
    .load_i      (we_data),
    .load_data_i (wdata_i),
    .drop_i      (act.tx_rst),
    .ready_i     (tx_ready_i),
    .valid_o     (tx_valid_o),
    .data_o      (tx_data_o),
    .empty_o     (txemp)
  );

  // interrupt flags
  logic [DATA_W-1:0] isr_q;
  logic              rx_int_d;

  assign rx_int_d = mode_q[0][RXSEL_BIT] ? rx_full_i : ~rx_empty_i;

  uart_regif_irq #(.DATA_W(DATA_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_int_d_i (tx_en_d),
    .rx_int_d_i (rx_int_d),
    .brk_set_i  (brk_i),
    .brk_clr_i  (act.brk_clr),
    .mask_i     (mask_q),
    .isr_o      (isr_q),
    .irq_o      (irq_o)
  );

  // status and read mux
  logic [DATA_W-1:0] stat;

  always_comb begin
    stat           = '0;
    stat[ST_RXRDY] = ~rx_empty_i;
    stat[ST_FULL]  = rx_full_i;
    stat[ST_TXRDY] = tx_en_q;
    stat[ST_TXEMP] = txemp;
  end

  always_comb begin
    rdata_o = '0;
    if (hit(addr_i, OFS_MODE))      rdata_o = mode_q[ptr_q];
    else if (hit(addr_i, OFS_STAT)) rdata_o = stat;
    else if (hit(addr_i, OFS_DATA)) rdata_o = rx_empty_i ? '0 : rx_data_i;
    else if (hit(addr_i, OFS_INT))  rdata_o = isr_q;
    else if (hit(addr_i, OFS_DIVL)) rdata_o = divl_q;
    else if (hit(addr_i, OFS_DIVH)) rdata_o = divh_q;
  end

  assign rx_pop_o   = rd_acc & hit(addr_i, OFS_DATA) & ~rx_empty_i;
  assign rx_flush_o = act.rx_rst;
  assign rx_en_o    = rx_en_q;
  assign div_lo_o   = divl_q;
  assign div_hi_o   = divh_q;

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PTR_W  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              brk_i,
  input logic              tx_ready_i,
  input logic              tx_valid_o,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              rx_pop_o,
  input logic              rx_empty_i,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [DATA_W-1:0] isr_q
);

  logic any_wr;
  assign any_wr = sel_i & wr_i;

  // R6
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !any_wr) |=> (tx_valid_o && $stable(tx_data_o)));

  // R6
  tx_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && !any_wr) |=> !tx_valid_o);

  // R7
  pop_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> (!rx_empty_i && sel_i && !wr_i));

  // R2
  ptr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_wr && addr_i == ADDR_W'(0)) |=> (ptr_q == PTR_W'(1)));

  // R8
  brk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> isr_q[2]);

  // R5
  tx_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_wr && addr_i == ADDR_W'(8) && wdata_i[6:4] == 3'd3 && wdata_i[3:2] != 2'd1)
      |=> !tx_valid_o);

endmodule

bind uart_regif uart_regif_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .PTR_W  (PTR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .brk_i      (brk_i),
  .tx_ready_i (tx_ready_i),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .rx_pop_o   (rx_pop_o),
  .rx_empty_i (rx_empty_i),
  .ptr_q      (ptr_q),
  .isr_q      (isr_q)
);

// File: tb/uart_regif_bench.sv
module uart_regif_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FDEPTH     = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, brk = 1'b0, tx_ready = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, tx_data, rx_data, div_lo, div_hi;
  logic       irq, tx_valid, rx_en, rx_pop, rx_flush, rx_empty, rx_full;

  // bench-side receive FIFO
  logic [7:0] fq [FDEPTH];
  int         fcnt = 0;
  assign rx_empty = (fcnt == 0);
  assign rx_full  = (fcnt == FDEPTH);
  assign rx_data  = fq[0];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif u_uart_regif (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_ready_i(tx_ready), .brk_i(brk), .rx_en_o(rx_en),
    .rx_pop_o(rx_pop), .rx_flush_o(rx_flush), .rx_empty_i(rx_empty),
    .rx_full_i(rx_full), .rx_data_i(rx_data), .div_lo_o(div_lo), .div_hi_o(div_hi)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state
  logic       m_tx_en = 0, m_rx_en = 0, m_txemp = 1, m_ptr = 0;
  logic [7:0] m_tb = 0, m_imr = 0, m_dlo = 0, m_dhi = 0;
  logic [7:0] m_mr [2] = '{8'h00, 8'h00};
  logic [2:0] m_isr = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [5:0] a);
    case (a)
      6'h00: return m_mr[m_ptr];
      6'h04: return {4'b0, m_txemp, m_tx_en, fcnt == FDEPTH, fcnt != 0};
      6'h0C: return (fcnt == 0) ? 8'h00 : fq[0];
      6'h14: return {5'b0, m_isr};
      6'h18: return m_dlo;
      6'h1C: return m_dhi;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [5:0] a);
    case (a)
      6'h00: return "R2 mode read";
      6'h04: return "R3 status read";
      6'h0C: return "R7 rx data read";
      6'h14: return "R8 flag read";
      6'h18, 6'h1C: return "R10 divisor read";
      default: return "R11 unmapped read";
    endcase
  endfunction

  task automatic step(input logic s, input logic w, input logic [5:0] a, input logic [7:0] d,
                      input logic b, input logic rdy, input logic push);
    logic       n_tx_en, n_rx_en, n_txemp, n_ptr, flush, pop, clr;
    logic [7:0] n_tb, n_imr, n_dlo, n_dhi, n_mr0, n_mr1, pdat;
    logic [2:0] n_isr;
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d; brk = b; tx_ready = rdy;
    #1;
    flush = s && w && a == 6'h08 && d[6:4] == 3'd2;
    pop   = s && !w && a == 6'h0C && fcnt != 0;
    clr   = s && w && a == 6'h08 && d[6:4] == 3'd5;
    chk("R6 tx_valid", {7'b0, tx_valid}, {7'b0, m_tx_en && !m_txemp});
    if (m_tx_en && !m_txemp) chk("R6 tx_data", tx_data, m_tb);
    chk("R9 irq", {7'b0, irq}, {7'b0, |({5'b0, m_isr} & m_imr)});
    chk("R4 rx_en", {7'b0, rx_en}, {7'b0, m_rx_en});
    chk("R5 rx_flush", {7'b0, rx_flush}, {7'b0, flush});
    chk("R7 rx_pop", {7'b0, rx_pop}, {7'b0, pop});
    chk("R10 div_lo", div_lo, m_dlo);
    chk("R10 div_hi", div_hi, m_dhi);
    if (s && !w) chk(rd_tag(a), rdata, exp_read(a));
    // next state from the requirements
    n_tx_en = m_tx_en; n_rx_en = m_rx_en; n_txemp = m_txemp; n_ptr = m_ptr;
    n_tb = m_tb; n_imr = m_imr; n_dlo = m_dlo; n_dhi = m_dhi;
    n_mr0 = m_mr[0]; n_mr1 = m_mr[1];
    if (m_tx_en && !m_txemp && rdy) n_txemp = 1;
    if (s && w) begin
      case (a)
        6'h00: begin
          if (m_ptr) n_mr1 = d; else n_mr0 = d;
          n_ptr = 1;
        end
        6'h08: begin
          case (d[6:4])
            3'd1: n_ptr = 0;
            3'd2: n_rx_en = 0;
            3'd3: begin n_tx_en = 0; n_txemp = 1; end
            default: ;
          endcase
          if (d[3:2] == 2'd1) n_tx_en = 1;
          if (d[3:2] == 2'd2) n_tx_en = 0;
          if (d[1:0] == 2'd1) n_rx_en = 1;
          if (d[1:0] == 2'd2) n_rx_en = 0;
        end
        6'h0C: begin n_tb = d; n_txemp = 0; end
        6'h14: n_imr = d;
        6'h18: n_dlo = d;
        6'h1C: n_dhi = d;
        default: ;
      endcase
    end
    n_isr[0] = n_tx_en;
    n_isr[1] = m_mr[0][6] ? (fcnt == FDEPTH) : (fcnt != 0);
    n_isr[2] = b ? 1'b1 : (clr ? 1'b0 : m_isr[2]);
    pdat = 8'($urandom);
    @(posedge clk);
    #1;
    if (flush) fcnt = 0;
    else begin
      if (pop) begin
        for (int i = 0; i < FDEPTH - 1; i++) fq[i] = fq[i+1];
        fcnt--;
      end
      if (push && m_rx_en && fcnt < FDEPTH) begin
        fq[fcnt] = pdat;
        fcnt++;
      end
    end
    m_tx_en = n_tx_en; m_rx_en = n_rx_en; m_txemp = n_txemp; m_ptr = n_ptr;
    m_tb = n_tb; m_imr = n_imr; m_dlo = n_dlo; m_dhi = n_dhi;
    m_mr[0] = n_mr0; m_mr[1] = n_mr1; m_isr = n_isr;
  endtask

  task automatic wrr(input logic [5:0] a, input logic [7:0] d);
    step(1, 1, a, d, 0, 0, 0);
  endtask

  task automatic rdr(input logic [5:0] a);
    step(1, 0, a, 8'h00, 0, 0, 0);
  endtask

  task automatic idle(input logic rdy, input logic push);
    step(0, 0, 6'h00, 8'h00, 0, rdy, push);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < FDEPTH; i++) fq[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    addr = 6'h04; #1; chk("R1 status after reset", rdata, 8'h08);
    addr = 6'h14; #1; chk("R1 flags after reset", rdata, 8'h00);
    addr = 6'h00; #1; chk("R1 mode A after reset", rdata, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    chk("R1 tx idle after reset", {7'b0, tx_valid}, 8'h00);
    chk("R1 rx disabled after reset", {7'b0, rx_en}, 8'h00);
    // R2 pointer
    wrr(6'h00, 8'h11); rdr(6'h00); wrr(6'h00, 8'h22); wrr(6'h00, 8'h33); rdr(6'h00);
    wrr(6'h08, 8'h10); rdr(6'h00); rdr(6'h00);
    // R3 / R11 ignored writes
    wrr(6'h04, 8'hFF); rdr(6'h04);
    wrr(6'h10, 8'hAA); wrr(6'h22, 8'h55); rdr(6'h10); rdr(6'h22); rdr(6'h04); rdr(6'h00);
    // R4 enable both, R9 mask
    wrr(6'h08, 8'h05); wrr(6'h14, 8'h07); rdr(6'h14); rdr(6'h04);
    // R6 handoff with stalls
    wrr(6'h0C, 8'hA5); idle(0, 0); idle(0, 0); idle(1, 0); idle(0, 0); rdr(6'h04);
    wrr(6'h0C, 8'h3C); wrr(6'h08, 8'h08); idle(1, 0); rdr(6'h04); wrr(6'h08, 8'h04); idle(1, 0);
    // R5 reset with pending byte, R4 same-byte override
    wrr(6'h0C, 8'h77); wrr(6'h08, 8'h30); rdr(6'h04); idle(1, 0);
    wrr(6'h0C, 8'h78); wrr(6'h08, 8'h34); rdr(6'h04); idle(1, 0);
    // R7 / R8 receive flags, full vs ready
    for (int i = 0; i < 6; i++) idle(0, 1);
    rdr(6'h04); rdr(6'h14);
    wrr(6'h08, 8'h10); wrr(6'h00, 8'h40); idle(0, 0); rdr(6'h14);
    rdr(6'h0C); idle(0, 0); rdr(6'h14); rdr(6'h0C); rdr(6'h0C); rdr(6'h0C); rdr(6'h0C); rdr(6'h04);
    for (int i = 0; i < 3; i++) idle(0, 1);
    wrr(6'h08, 8'h20); rdr(6'h04); idle(0, 1); rdr(6'h04);
    // R8 break flag and clear, set wins
    step(0, 0, 6'h00, 8'h00, 1, 0, 0); rdr(6'h14); wrr(6'h08, 8'h50); rdr(6'h14);
    step(1, 1, 6'h08, 8'h50, 1, 0, 0); rdr(6'h14);
    // R10 divisors
    wrr(6'h18, 8'h9A); wrr(6'h1C, 8'hBC); rdr(6'h18); rdr(6'h1C);
    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [5:0] a;
      logic [7:0] d;
      int         sel_ofs;
      sel_ofs = int'($urandom % 10);
      case (sel_ofs)
        0: a = 6'h00; 1: a = 6'h04; 2, 8: a = 6'h08; 3, 9: a = 6'h0C;
        4: a = 6'h10; 5: a = 6'h14; 6: a = 6'h18; default: a = 6'($urandom);
      endcase
      d = 8'($urandom);
      if (a == 6'h08 && ($urandom % 4) != 0) d[6:4] = 3'd0;
      step(($urandom % 4) != 0, ($urandom % 2) != 0, a, d,
           ($urandom % 32) == 0, ($urandom % 2) != 0, ($urandom % 2) != 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule